// File: doc/BRIEF.md
# Key-Locked Two-Stage Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. Every access takes one cycle and is marked by a single strobe. A 32-bit down-counter runs on the core clock. Software programs a reload value and enables the counter. It must then service the watchdog on time. Servicing means clearing the pending interrupt, and that clear also refills the counter.

The first time the count runs out, the block raises an interrupt and starts a new period. If the count runs out a second time while that interrupt is still pending, and reset generation is enabled, the block drives a system reset pulse of fixed length. All writes except those to the lock register are blocked until software writes a magic key to the lock register. Writing any other value to the lock register blocks them again.

Byte offsets: reload value 0x000, live count 0x004, control 0x008, service 0x00C, interrupt status 0x014, lock 0xC00.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the lock register reads 1, control reads 0, the reload value and the live count both read 0xFFFFFFFF, and irq_o and sys_rst_o are low.
- R2: Writing exactly 0x1ACCE551 to offset 0xC00 unlocks the block, after which the lock register reads 0. Writing any other value to 0xC00 locks it again, after which it reads 1.
- R3: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C change nothing. Reads are always allowed.
- R4: An unlocked write to 0x000 stores the reload value and also loads the live count with that value on the same clock edge.
- R5: With control bit 0 set, the count drops by one each clock. On the clock after it reaches zero it refills from the reload value, and the interrupt becomes pending. For a reload value L, irq_o rises L+1 clocks after the edge that enables the counter.
- R6: Clearing control bit 0 freezes the live count. It also forces irq_o low, while the status register (0x014) keeps reading 1.
- R7: An unlocked write of any data to 0x00C clears the pending interrupt and refills the live count from the reload value.
- R8: If control bit 1 is set and the count expires while the interrupt is pending, sys_rst_o goes high for exactly RST_PULSE clocks (default 4). It then stays low until rst_n, even if further expiries happen.
- R9: If control bit 1 is clear, a second expiry with the interrupt pending leaves sys_rst_o low.
- R10: Control bits 31:2 read as 0. The status register reads 1 while the interrupt is pending and 0 otherwise. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Interrupt: pending flag gated by control bit 0 |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The counter is run with small reload values so that both expiries fall within a few dozen cycles. The bench samples irq_o on the cycle before the expected expiry and on the expiry cycle itself, which exposes any off-by-one error in the period. The same two-expiry pattern is run twice, once with reset generation enabled and once with it disabled. This separates reset caused by the second expiry from reset that ignores the enable bit. The pulse is also watched well after it ends, to show it does not fire again. Writes are issued both while locked and after unlocking, which separates a lock that blocks writes from one that only changes what the lock register reads back. Freezing the counter and servicing the interrupt are each checked through the live count and the status register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_SVC    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;

  localparam logic [31:0] KEY_OPEN = 32'h1ACC_E551;

  // One step of the down-counter; a zero count wraps to the reload value.
  function automatic logic [31:0] f_step(input logic [31:0] cnt, input logic [31:0] rld);
    return (cnt == '0) ? rld : cnt - 32'd1;
  endfunction

  // Lock state that follows a write of the given value to the lock register.
  function automatic logic f_lock_after(input logic [31:0] wdata);
    return wdata != KEY_OPEN;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              pending,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              locked,
  output logic [DATA_W-1:0] reload_q,
  output logic              en_q,
  output logic              rsten_q,
  output logic              reload_wr,
  output logic              svc_wr
);
  logic wr_any, wr_open, ctrl_wr, lock_wr;

  assign wr_any    = bus_sel && bus_wr;
  assign wr_open   = wr_any && !locked;
  assign lock_wr   = wr_any && (bus_addr == OFS_LOCK);
  assign reload_wr = wr_open && (bus_addr == OFS_RELOAD);
  assign ctrl_wr   = wr_open && (bus_addr == OFS_CTRL);
  assign svc_wr    = wr_open && (bus_addr == OFS_SVC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b1;
      reload_q <= RELOAD_RST[DATA_W-1:0];
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
    end else begin
      if (lock_wr)   locked   <= f_lock_after(32'(bus_wdata));
      if (reload_wr) reload_q <= bus_wdata;
      if (ctrl_wr) begin
        en_q    <= bus_wdata[0];
        rsten_q <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_RELOAD: bus_rdata = reload_q;
      OFS_COUNT:  bus_rdata = cnt;
      OFS_CTRL:   bus_rdata[1:0] = {rsten_q, en_q};
      OFS_STAT:   bus_rdata[0] = pending;
      OFS_LOCK:   bus_rdata[0] = locked;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              reload_wr,
  input  logic [DATA_W-1:0] reload_data,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] cnt,
  output logic              expire
);
  logic refill;

  assign refill = reload_wr || svc_wr;
  assign expire = en && !refill && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= RELOAD_RST[DATA_W-1:0];
    else if (reload_wr) cnt <= reload_data;
    else if (svc_wr)    cnt <= reload_q;
    else if (en)        cnt <= DATA_W'(f_step(32'(cnt), 32'(reload_q)));
  end
endmodule

// File: rtl/wdog_event.sv
module wdog_event #(
  parameter int RST_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic svc_wr,
  input  logic rsten,
  output logic pending,
  output logic sys_rst
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] pulse_cnt;
  logic          fired;
  logic          bite;

  assign bite    = expire && pending && rsten && !fired;
  assign sys_rst = (pulse_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      pulse_cnt <= '0;
      fired     <= 1'b0;
    end else begin
      if (svc_wr)      pending <= 1'b0;
      else if (expire) pending <= 1'b1;
      if (bite) begin
        pulse_cnt <= PW'(RST_PULSE);
        fired     <= 1'b1;
      end else if (pulse_cnt != '0) begin
        pulse_cnt <= pulse_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          RST_PULSE  = 4,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic              locked, en_q, rsten_q, reload_wr, svc_wr;
  logic              expire, pending;
  logic [DATA_W-1:0] reload_q, cnt;

  wdog_regs #(.DATA_W(DATA_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .pending(pending),
    .bus_rdata(bus_rdata), .locked(locked), .reload_q(reload_q), .en_q(en_q),
    .rsten_q(rsten_q), .reload_wr(reload_wr), .svc_wr(svc_wr)
  );

  wdog_counter #(.DATA_W(DATA_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .reload_wr(reload_wr),
    .reload_data(bus_wdata), .svc_wr(svc_wr), .reload_q(reload_q),
    .cnt(cnt), .expire(expire)
  );

  wdog_event #(.RST_PULSE(RST_PULSE)) u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expire), .svc_wr(svc_wr),
    .rsten(rsten_q), .pending(pending), .sys_rst(sys_rst_o)
  );

  assign irq_o = pending && en_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic              en_q,
  input logic              rsten_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              reload_wr,
  input logic              svc_wr,
  input logic [DATA_W-1:0] cnt,
  input logic              expire,
  input logic              pending,
  input logic              sys_rst_o
);
  a_r3_locked_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(en_q) && $stable(rsten_q) && $stable(reload_q)));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !reload_wr && !svc_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r5_expire_pends: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);

  a_r6_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reload_wr && !svc_wr) |=> $stable(cnt));

  a_r7_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    svc_wr |=> (!pending && cnt == $past(reload_q)));

  a_r8_bite_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($past(pending) && $past(rsten_q) && $past(expire)));
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .en_q(en_q), .rsten_q(rsten_q),
  .reload_q(reload_q), .reload_wr(reload_wr), .svc_wr(svc_wr), .cnt(cnt),
  .expire(expire), .pending(pending), .sys_rst_o(sys_rst_o)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
  localparam int PULSE = 4;
  localparam logic [11:0] A_RLD = 12'h000, A_CNT = 12'h004, A_CTL = 12'h008,
                          A_SVC = 12'h00C, A_STA = 12'h014, A_LCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_o, sys_rst_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_keyed #(.RST_PULSE(PULSE)) i_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Ends on the falling edge after the write edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_LCK, v); check("R1 lock", v, 1);
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    rd(A_RLD, v); check("R1 reload", v, 32'hFFFFFFFF);
    rd(A_CNT, v); check("R1 count", v, 32'hFFFFFFFF);
    check("R1 irq", irq_o, 0);
    check("R1 sysrst", sys_rst_o, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(A_LCK, KEY);           rd(A_LCK, v); check("R2 unlocked", v, 0);
    wr(A_LCK, KEY ^ 32'h1);   rd(A_LCK, v); check("R2 relocked", v, 1);
  endtask

  task automatic t_locked_ignored();
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 32'h55);
    wr(A_CTL, 32'h3);
    rd(A_RLD, v); check("R3 reload kept", v, 32'hFFFFFFFF);
    rd(A_CTL, v); check("R3 ctrl kept", v, 0);
    rd(A_CNT, v); check("R3 count kept", v, 32'hFFFFFFFF);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    do_reset();
    wr(A_LCK, KEY);
    wr(A_RLD, 32'h1234);
    rd(A_RLD, v); check("R4 reload", v, 32'h1234);
    rd(A_CNT, v); check("R4 count", v, 32'h1234);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    do_reset();
    wr(A_LCK, KEY); wr(A_RLD, 5); wr(A_CTL, 1);
    edges(2); rd(A_CNT, v); check("R5 count step", v, 3);
    edges(3); check("R5 irq before", irq_o, 0);
    rd(A_CNT, v); check("R5 count zero", v, 0);
    edges(1); check("R5 irq at expiry", irq_o, 1);
    rd(A_CNT, v); check("R5 refill", v, 5);
    rd(A_STA, v); check("R10 status pending", v, 1);
  endtask

  task automatic t_disable();
    logic [31:0] v, w;
    do_reset();
    wr(A_LCK, KEY); wr(A_RLD, 3); wr(A_CTL, 1);
    edges(4); check("R6 irq up", irq_o, 1);
    wr(A_CTL, 0);
    check("R6 irq masked", irq_o, 0);
    rd(A_STA, v); check("R6 status kept", v, 1);
    rd(A_CNT, v); edges(5); rd(A_CNT, w); check("R6 count frozen", w, v);
  endtask

  task automatic t_service();
    logic [31:0] v;
    do_reset();
    wr(A_LCK, KEY); wr(A_RLD, 3); wr(A_CTL, 1);
    edges(4);
    wr(A_LCK, 0); wr(A_SVC, 1);
    rd(A_STA, v); check("R3 locked service ignored", v, 1);
    wr(A_LCK, KEY); wr(A_SVC, 32'hABCD);
    rd(A_STA, v); check("R7 pending cleared", v, 0);
    check("R7 irq low", irq_o, 0);
    rd(A_CNT, v); check("R7 count refilled", v, 3);
  endtask

  task automatic t_bite();
    do_reset();
    wr(A_LCK, KEY); wr(A_RLD, 6); wr(A_CTL, 3);
    edges(7); check("R8 first expiry irq", irq_o, 1);
    check("R8 no reset at first", sys_rst_o, 0);
    edges(6); check("R8 reset before second", sys_rst_o, 0);
    edges(1); check("R8 reset starts", sys_rst_o, 1);
    edges(PULSE - 1); check("R8 reset held", sys_rst_o, 1);
    edges(1); check("R8 reset ends", sys_rst_o, 0);
    for (int i = 0; i < 30; i++) begin
      edges(1);
      if (sys_rst_o) begin check("R8 no second pulse", sys_rst_o, 0); break; end
    end
    check("R8 stays low", sys_rst_o, 0);
  endtask

  task automatic t_no_bite();
    do_reset();
    wr(A_LCK, KEY); wr(A_RLD, 4); wr(A_CTL, 1);
    for (int i = 0; i < 20; i++) begin
      edges(1);
      if (sys_rst_o) begin check("R9 reset disabled", sys_rst_o, 0); break; end
    end
    check("R9 irq pending", irq_o, 1);
    check("R9 no reset", sys_rst_o, 0);
  endtask

  task automatic t_readmap();
    logic [31:0] v;
    do_reset();
    wr(A_LCK, KEY); wr(A_CTL, 32'hFFFFFFFF);
    rd(A_CTL, v);   check("R10 ctrl reserved", v, 3);
    rd(A_STA, v);   check("R10 status idle", v, 0);
    rd(12'h010, v); check("R10 unmapped", v, 0);
    rd(A_SVC, v);   check("R10 service reads 0", v, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock();
    t_locked_ignored();
    t_reload();
    t_expire();
    t_disable();
    t_service();
    t_bite();
    t_no_bite();
    t_readmap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule